// File: doc/BRIEF.md
# Host I/O base address decoder

This block holds a small bank of base address entries that map the host's 16-bit I/O address space onto device frames of an internal peripheral bus. Every entry carries a 16-bit host base, an 8-bit match mask, a 6-bit frame number and a valid flag. When the host presents an I/O address with a strobe, all entries are compared in parallel. One clock later the block reports whether an entry claimed the address, which entry it was, and the address translated into peripheral space: the frame number scaled by 0x400, plus the host address bits that the mask leaves out of the compare.

Entries are programmed through a 32-bit write port with byte enables. Within an entry word, bits 31:16 hold the base, bit 15 the valid flag, bits 13:8 the frame and bits 7:0 the mask. Byte lane 0 is the mask, lane 1 holds the valid flag and the frame, lane 2 is the low byte of the base and lane 3 is the high byte of the base.

Entry 0 serves the host interface itself. Its base is loaded through a one-byte shadow so that a 16-bit value changes in a single step. Entry 0 and the shadow are cleared only by the system reset. The other entries are cleared by a separate I/O-subsystem reset. A lock input blocks every write while it is high.

Top module: `hio_bar_decoder`

## Requirements
- R1: After reset, and while the decode strobe is high, no address produces a hit: `hit_o` is 0, `hit_idx_o` is 0 and `paddr_o` is 0, because every valid flag resets to 0.
- R2: A valid entry matches an address when the upper 8 address bits equal the upper 8 base bits, and each of the low 8 address bits either equals its base bit or has its mask bit set to 1.
- R3: On a hit, `paddr_o` equals frame × 0x400 plus (address AND mask). Bits 9:8 of `paddr_o` are therefore 0.
- R4: `hit_o`, `hit_idx_o` and `paddr_o` take their value at the first rising edge after the strobe is sampled high. A clock edge with the strobe low gives `hit_o` = 0 and all outputs 0.
- R5: When several entries match, the entry with the lowest index is reported.
- R6: A valid entry whose frame number is absent from the present-frame set never hits. By default, frames 0 to 15 are present and frames 16 to 63 are absent.
- R7: A write to entry 0 that enables lane 2 but not lane 3 stores data bits 23:16 only in the shadow. The live base of entry 0 keeps its value.
- R8: A write to entry 0 that enables lane 3 sets the live base to {data[31:24], shadow}. The shadow value used is the one this same write leaves. After a system reset the shadow is 0x00.
- R9: For entries other than 0, each enabled lane updates its own field directly. Lane 2 writes base bits 7:0 and lane 3 writes base bits 15:8. A disabled lane, or a write to another entry, leaves the field unchanged.
- R10: While `wr_lock` is 1, writes change no entry and no shadow.
- R11: The I/O-subsystem reset clears entries 1 and up but not entry 0. The system reset clears entry 0, its shadow and the outputs, but not entries 1 and up.
- R12: An entry whose valid flag (bit 15) is 0 never hits, whatever its base, mask and frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | Synchronous active-low system reset (entry 0, shadow, outputs) |
| sio_rst_n | input | 1 | Synchronous active-low I/O-subsystem reset (entries 1 and up) |
| wr_lock | input | 1 | When 1, all entry writes are ignored |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Index of the entry to write |
| wr_be | input | 4 | Byte lane enables for `wr_data` |
| wr_data | input | 32 | Entry word: base 31:16, valid 15, frame 13:8, mask 7:0 |
| dec_valid | input | 1 | Decode strobe |
| dec_addr | input | 16 | Host I/O address to decode |
| hit_o | output | 1 | An entry claimed the last strobed address |
| hit_idx_o | output | IDX_W | Index of the winning entry |
| paddr_o | output | 16 | Translated peripheral bus address |

## Verification
The hardest states to reach from the ports involve entry 0's shadow. These are a low-byte write that must leave the live base untouched, a high-byte write that commits a shadow filled much earlier or never filled, and a shadow write attempted under lock that must not disturb a later commit. Directed sequences build these states and then probe the old and new base addresses through the decode path. The two resets are pulsed one at a time, and decodes afterwards show which entries survived each one. Random writes with random byte lanes and occasional lock then run alongside decodes. The decode addresses are biased to fall near the programmed bases, so masked and overlapping matches come up often.

// File: rtl/hio_bar_pkg.sv
// Package: hio_bar_pkg
// Shared field layout of one base address entry word and the decoded entry type.
// Assumes a 16-bit host I/O address and an 8-bit mask covering the low address byte.
package hio_bar_pkg;

    localparam int HBASE_W     = 16;
    localparam int MASK_W      = 8;
    localparam int FRAME_W     = 6;
    localparam int FRAME_SHIFT = 10;
    localparam int PADDR_W     = FRAME_W + FRAME_SHIFT;
    localparam int WORD_W      = 32;
    localparam int LANES       = WORD_W / 8;

    // bit positions inside the written entry word
    localparam int MASK_LSB    = 0;
    localparam int FRAME_LSB   = 8;
    localparam int VALID_BIT   = 15;
    localparam int BASE_LSB    = 16;

    typedef struct packed {
        logic [HBASE_W-1:0] base;
        logic               valid;
        logic [FRAME_W-1:0] frame;
        logic [MASK_W-1:0]  mask;
    } bar_entry_t;

endpackage

// File: rtl/hio_bar_entry.sv
// Module: hio_bar_entry
// One base address entry register. Byte lanes of the write word update their fields.
// With SHADOWED set, the base low byte goes through a shadow and the base is
// committed whole on a high-byte write. Assumes wr_sel is one cycle per write.
module hio_bar_entry
    import hio_bar_pkg::*;
#(
    parameter bit SHADOWED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lock,
    input  logic              wr_sel,
    input  logic [LANES-1:0]  wr_be,
    input  logic [WORD_W-1:0] wr_data,
    output bar_entry_t        entry_o
);

    bar_entry_t        entry_q;
    logic [7:0]        shadow_q;
    logic [7:0]        shadow_next;
    logic              wr_ok;

    assign wr_ok = wr_sel && !wr_lock;

    // shadow value after this cycle's write, used by a same-cycle commit
    always_comb begin
        shadow_next = shadow_q;
        if (wr_ok && wr_be[2]) begin
            shadow_next = wr_data[BASE_LSB +: 8];
        end
    end

    generate
        if (SHADOWED) begin : g_shadow
            // shadow byte register for the base low byte
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shadow_q <= '0;
                end else begin
                    shadow_q <= shadow_next;
                end
            end

            p_lowbyte_shadow_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && wr_sel && !wr_lock && wr_be[2] && !wr_be[3]) |=> $stable(entry_q.base));

            p_commit_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && wr_sel && !wr_lock && wr_be[3]) |=> (entry_q.base[15:8] == $past(wr_data[31:24])));

            p_shadow_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && wr_lock) |=> $stable(shadow_q));
        end else begin : g_noshadow
            assign shadow_q = '0;
        end
    endgenerate

    // entry field update from the enabled byte lanes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= '0;
        end else if (wr_ok) begin
            if (wr_be[0]) begin
                entry_q.mask <= wr_data[MASK_LSB +: MASK_W];
            end
            if (wr_be[1]) begin
                entry_q.frame <= wr_data[FRAME_LSB +: FRAME_W];
                entry_q.valid <= wr_data[VALID_BIT];
            end
            if (SHADOWED) begin
                if (wr_be[3]) begin
                    entry_q.base <= {wr_data[BASE_LSB+8 +: 8], shadow_next};
                end
            end else begin
                if (wr_be[2]) begin
                    entry_q.base[7:0] <= wr_data[BASE_LSB +: 8];
                end
                if (wr_be[3]) begin
                    entry_q.base[15:8] <= wr_data[BASE_LSB+8 +: 8];
                end
            end
        end
    end

    assign entry_o = entry_q;

    p_lock_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_lock) |=> $stable(entry_q));

    p_unselected_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_sel) |=> $stable(entry_q));

endmodule

// File: rtl/hio_bar_match.sv
// Module: hio_bar_match
// Combinational compare of one host address against one entry, plus the
// translated peripheral address. Assumes the mask covers only the low address byte.
module hio_bar_match
    import hio_bar_pkg::*;
#(
    parameter logic [63:0] FRAME_PRESENT = 64'h0000_0000_0000_FFFF
) (
    input  bar_entry_t          entry_i,
    input  logic [HBASE_W-1:0]  addr_i,
    output logic                match_o,
    output logic [PADDR_W-1:0]  paddr_o
);

    logic [HBASE_W-1:0] care;
    logic [HBASE_W-1:0] diff;
    logic               present;

    // address bits that take part in the compare
    always_comb begin
        care = {{(HBASE_W-MASK_W){1'b1}}, ~entry_i.mask};
        diff = (addr_i ^ entry_i.base) & care;
    end

    assign present = FRAME_PRESENT[entry_i.frame];
    assign match_o = entry_i.valid && present && (diff == '0);

    // frame base plus the masked-out offset bits
    always_comb begin
        paddr_o = {entry_i.frame, {FRAME_SHIFT{1'b0}}}
                | PADDR_W'(addr_i[MASK_W-1:0] & entry_i.mask);
    end

endmodule

// File: rtl/hio_bar_prio.sv
// Module: hio_bar_prio
// Fixed-priority pick of the lowest-numbered set request.
// Assumes N >= 2.
module hio_bar_prio #(
    parameter int N     = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             grant_valid_o,
    output logic [IDX_W-1:0] grant_idx_o
);

    // scan from the top so the lowest set index wins
    always_comb begin
        grant_valid_o = 1'b0;
        grant_idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_valid_o = 1'b1;
                grant_idx_o   = IDX_W'(i);
            end
        end
    end

    // checks on the chosen request
    always_comb begin
        if (grant_valid_o) begin
            p_grant_is_req_r5: assert (req_i[grant_idx_o]);
            p_grant_lowest_r5: assert ((req_i & ((N'(1) << grant_idx_o) - N'(1))) == '0);
        end else begin
            p_grant_none_r5: assert (req_i == '0);
        end
    end

endmodule

// File: rtl/hio_bar_decoder.sv
// Module: hio_bar_decoder
// Bank of host I/O base address entries with a registered decode result.
// Entry 0 is shadowed and sits in the system reset domain. The other entries
// sit in the I/O-subsystem reset domain. Assumes both resets are synchronous
// to clk.
module hio_bar_decoder
    import hio_bar_pkg::*;
#(
    parameter int          NUM_ENTRIES   = 4,
    parameter logic [63:0] FRAME_PRESENT = 64'h0000_0000_0000_FFFF,
    localparam int         IDX_W         = $clog2(NUM_ENTRIES)
) (
    input  logic               clk,
    input  logic               sys_rst_n,
    input  logic               sio_rst_n,
    input  logic               wr_lock,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [LANES-1:0]   wr_be,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               dec_valid,
    input  logic [HBASE_W-1:0] dec_addr,
    output logic               hit_o,
    output logic [IDX_W-1:0]   hit_idx_o,
    output logic [PADDR_W-1:0] paddr_o
);

    bar_entry_t         entries [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] match;
    logic [PADDR_W-1:0] paddr_arr [NUM_ENTRIES];
    logic               any_hit;
    logic [IDX_W-1:0]   win_idx;

    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
            logic sel;
            logic rst_n_g;
            assign sel     = wr_en && (wr_idx == IDX_W'(g));
            assign rst_n_g = (g == 0) ? sys_rst_n : sio_rst_n;

            hio_bar_entry #(
                .SHADOWED (g == 0)
            ) i_entry (
                .clk     (clk),
                .rst_n   (rst_n_g),
                .wr_lock (wr_lock),
                .wr_sel  (sel),
                .wr_be   (wr_be),
                .wr_data (wr_data),
                .entry_o (entries[g])
            );

            hio_bar_match #(
                .FRAME_PRESENT (FRAME_PRESENT)
            ) i_match (
                .entry_i (entries[g]),
                .addr_i  (dec_addr),
                .match_o (match[g]),
                .paddr_o (paddr_arr[g])
            );
        end
    endgenerate

    hio_bar_prio #(
        .N     (NUM_ENTRIES),
        .IDX_W (IDX_W)
    ) i_prio (
        .req_i         (match),
        .grant_valid_o (any_hit),
        .grant_idx_o   (win_idx)
    );

    // register the decode result one clock after the strobe
    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            hit_o     <= 1'b0;
            hit_idx_o <= '0;
            paddr_o   <= '0;
        end else if (dec_valid && any_hit) begin
            hit_o     <= 1'b1;
            hit_idx_o <= win_idx;
            paddr_o   <= paddr_arr[win_idx];
        end else begin
            hit_o     <= 1'b0;
            hit_idx_o <= '0;
            paddr_o   <= '0;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !sys_rst_n |=> (!hit_o && paddr_o == '0));

    p_idle_no_hit_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (sys_rst_n && !dec_valid) |=> !hit_o);

    p_present_frame_r6: assert property (@(posedge clk) disable iff (!sys_rst_n)
        hit_o |-> FRAME_PRESENT[paddr_o[PADDR_W-1:FRAME_SHIFT]]);

    p_offset_width_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
        hit_o |-> (paddr_o[FRAME_SHIFT-1:MASK_W] == '0));

    p_miss_zero_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !hit_o |-> (paddr_o == '0 && hit_idx_o == '0));

endmodule

// File: tb/test_hio_bar_decoder.sv
module test_hio_bar_decoder;

    localparam int N = 4;
    localparam int IW = 2;
    localparam logic [63:0] PRES = 64'h0000_0000_0000_FFFF;
    localparam real CLK_NS = 5.0;

    logic clk = 0;
    logic sys_rst_n, sio_rst_n, wr_lock, wr_en, dec_valid;
    logic [IW-1:0] wr_idx;
    logic [3:0] wr_be;
    logic [31:0] wr_data;
    logic [15:0] dec_addr;
    logic hit_o;
    logic [IW-1:0] hit_idx_o;
    logic [15:0] paddr_o;

    hio_bar_decoder #(.NUM_ENTRIES(N), .FRAME_PRESENT(PRES)) i_hio_bar_decoder (
        .clk(clk), .sys_rst_n(sys_rst_n), .sio_rst_n(sio_rst_n), .wr_lock(wr_lock),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_be(wr_be), .wr_data(wr_data),
        .dec_valid(dec_valid), .dec_addr(dec_addr),
        .hit_o(hit_o), .hit_idx_o(hit_idx_o), .paddr_o(paddr_o));

    always #(CLK_NS/2) clk = ~clk;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    logic [15:0] m_base [N];
    logic [7:0]  m_mask [N];
    logic [5:0]  m_frame [N];
    logic        m_valid [N];
    logic [7:0]  m_shadow;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr_sio();
        for (int i = 1; i < N; i++) begin
            m_base[i] = 0; m_mask[i] = 0; m_frame[i] = 0; m_valid[i] = 0;
        end
    endtask

    task automatic clr_sys();
        m_base[0] = 0; m_mask[0] = 0; m_frame[0] = 0; m_valid[0] = 0; m_shadow = 0;
    endtask

    function automatic void exp_decode(input logic [15:0] a, output logic h,
                                       output logic [IW-1:0] ix, output logic [15:0] pa);
        h = 0; ix = 0; pa = 0;
        for (int i = 0; i < N; i++) begin
            if (!h && m_valid[i] && PRES[m_frame[i]] &&
                (a[15:8] == m_base[i][15:8]) &&
                (((a[7:0] ^ m_base[i][7:0]) & ~m_mask[i]) == 8'h00)) begin
                h = 1; ix = IW'(i);
                pa = {m_frame[i], 10'b0} + {8'h00, a[7:0] & m_mask[i]};
            end
        end
    endfunction

    task automatic wr(input int idx, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_idx = IW'(idx); wr_be = be; wr_data = d;
        if (!wr_lock) begin
            if (be[0]) m_mask[idx] = d[7:0];
            if (be[1]) begin m_frame[idx] = d[13:8]; m_valid[idx] = d[15]; end
            if (idx == 0) begin
                if (be[2]) m_shadow = d[23:16];
                if (be[3]) m_base[0] = {d[31:24], m_shadow};
            end else begin
                if (be[2]) m_base[idx][7:0] = d[23:16];
                if (be[3]) m_base[idx][15:8] = d[31:24];
            end
        end
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic dec(input logic [15:0] a, input string req);
        logic h; logic [IW-1:0] ix; logic [15:0] pa;
        @(negedge clk);
        dec_valid = 1; dec_addr = a;
        exp_decode(a, h, ix, pa);
        @(negedge clk);
        dec_valid = 0;
        check({req, " hit"}, 32'(hit_o), 32'(h));
        check({req, " idx"}, 32'(hit_idx_o), 32'(ix));
        check({req, " paddr"}, 32'(paddr_o), 32'(pa));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'd7411);
        sys_rst_n = 0; sio_rst_n = 0; wr_lock = 0; wr_en = 0; dec_valid = 1;
        wr_idx = 0; wr_be = 0; wr_data = 0; dec_addr = 16'h0000;
        clr_sio(); clr_sys();
        repeat (3) @(negedge clk);
        // R1: outputs cleared in reset even with strobe high
        check("R1 reset hit", 32'(hit_o), 0);
        check("R1 reset paddr", 32'(paddr_o), 0);
        dec_valid = 0;
        sys_rst_n = 1; sio_rst_n = 1;
        dec(16'h0000, "R1 empty bank");
        dec(16'h0305, "R1 empty bank");

        // R2 R3: entry1 base 0x0300 mask 0x0F frame 3
        wr(1, 4'hF, 32'h0300_830F);
        dec(16'h0305, "R2 R3 masked hit");
        check("R3 paddr value", 32'(paddr_o), 32'h0C05);
        dec(16'h0315, "R2 unmasked bit differs");
        dec(16'h030F, "R3 top offset");
        dec(16'h0405, "R2 upper byte differs");

        // R4: strobe low gives no hit on following edge
        @(negedge clk);
        dec_addr = 16'h0305;
        @(negedge clk);
        check("R4 no strobe", 32'(hit_o), 0);

        // R12: valid flag gates the match
        wr(2, 4'hF, 32'h0400_0205);
        dec(16'h0400, "R12 valid clear");
        wr(2, 4'b0010, 32'h0000_8200);
        dec(16'h0400, "R12 valid set");

        // R6: absent frame 20
        wr(3, 4'hF, 32'h0500_9400);
        dec(16'h0500, "R6 absent frame");

        // R5: overlapping entries 1 and 2
        wr(2, 4'hF, 32'h0300_82FF);
        dec(16'h0305, "R5 lowest wins");
        check("R5 idx one", 32'(hit_idx_o), 1);
        dec(16'h0345, "R5 only entry2");

        // R8 R7: entry 0 shadowed base
        wr(0, 4'b0011, 32'h0000_8100);
        dec(16'h0000, "R8 entry0 base zero");
        wr(0, 4'b1000, 32'h6200_0000);
        dec(16'h6200, "R8 commit with reset shadow");
        wr(0, 4'b0100, 32'h0034_0000);
        dec(16'h6200, "R7 low byte shadow only");
        dec(16'h6234, "R7 low byte not live");
        wr(0, 4'b1000, 32'h6000_0000);
        dec(16'h6034, "R8 commit shadow");
        dec(16'h6200, "R8 old base gone");

        // R9: direct lane writes on entry 3
        wr(3, 4'b0100, 32'h0011_0000);
        wr(3, 4'b0010, 32'h0000_8500);
        dec(16'h0511, "R9 lane2 then frame");

        // R10: lock
        wr_lock = 1;
        wr(1, 4'hF, 32'h0700_8100);
        dec(16'h0305, "R10 locked entry1 kept");
        dec(16'h0700, "R10 locked no new base");
        wr(0, 4'b0100, 32'h00AA_0000);
        wr_lock = 0;
        wr(0, 4'b1000, 32'h6000_0000);
        dec(16'h6034, "R10 shadow kept under lock");

        // R11: separate reset domains
        @(negedge clk); sio_rst_n = 0; clr_sio();
        @(negedge clk); sio_rst_n = 1;
        dec(16'h0305, "R11 sio reset clears entry1");
        dec(16'h6034, "R11 sio reset keeps entry0");
        wr(1, 4'hF, 32'h0300_830F);
        @(negedge clk); sys_rst_n = 0; clr_sys();
        @(negedge clk); sys_rst_n = 1;
        dec(16'h6034, "R11 sys reset clears entry0");
        dec(16'h0305, "R11 sys reset keeps entry1");
        wr(0, 4'b0010, 32'h0000_8100);
        wr(0, 4'b1000, 32'h1200_0000);
        dec(16'h1200, "R11 R8 shadow cleared by sys reset");

        // R9 R2 R3 R5: random mix
        for (int it = 0; it < 400; it++) begin
            int k;
            logic [15:0] a;
            k = int'($urandom_range(0, 9));
            if (k < 3) begin
                wr_lock = ($urandom_range(0, 7) == 0);
                wr(int'($urandom_range(0, N - 1)), 4'($urandom_range(0, 15)),
                   {8'h03, 8'($urandom_range(0, 255)), 1'($urandom_range(0, 7) != 0),
                    1'b0, 6'($urandom_range(0, 20)), 8'($urandom_range(0, 255))});
                wr_lock = 0;
            end else begin
                int e;
                e = int'($urandom_range(0, N - 1));
                a = m_base[e] ^ 16'($urandom_range(0, 31));
                if (k == 9) a = 16'($urandom);
                dec(a, "R9 R2 R3 R5 random");
            end
        end
        finish_run();
    end

endmodule